// File: doc/BRIEF.md
# Sector Transfer Termination Sequencer

This block steps a multi-sector data transfer command through three phases. In the command phase it accepts a start sector, a last sector number (`eot_sec_i`), a 3-bit size code, a track and a head. In the execution phase it counts bytes and sectors. In the result phase it offers a fixed set of result bytes to the host. It does not store data and it does not touch the media. It only decides when the transfer ends and how that end is reported.

A transfer can end in three ways. An explicit terminal count (`tc_i`) gives a normal completion. A host stop partway through a sector (`host_stop_i`, which stands for an underrun or overrun) gives an abnormal completion. Reaching the last sector number without a terminal count also gives an abnormal completion. Whenever the end comes mid-sector, the sequencer fills out the remaining bytes of that sector by itself, at one byte per clock. The three endings then behave the same way and differ only in their status bits.

`byte_i` marks the moment the disk side consumes or produces one byte. On writes this strobe can trail the host's last write by up to a FIFO depth. The sector count therefore closes only when the final byte is actually taken.

Top module: `xts_seq`

## Requirements
- R1: After reset, phase_o is 0 (command), int_o is 0 and status_o is 0.
- R2: cmd_valid_i is accepted only in the command phase, and phase_o becomes 1 (execution) on the next cycle. A command attempted in the execution or result phase changes neither the phase nor the latched parameters, and it sets status bit 5. That bit stays set until the next accepted command, which clears it.
- R3: A sector holds 128 << size_code bytes. Each byte_i strobe in the execution phase counts one byte. byte_i, tc_i and host_stop_i are ignored outside the execution phase.
- R4: After each complete sector the sector number increments. The transfer ends at the close of the first sector whose number is greater than or equal to the last sector number.
- R5: tc_i in the execution phase ends the transfer at the close of the current sector. From the next cycle onward the remaining bytes are filled in at one per clock without byte_i. Status bit 6 reads 0 (normal), and result byte 2 reads 1.
- R6: host_stop_i fills out the sector in the same way, but status bit 6 reads 1 (abnormal) and result byte 1 bit 4 reads 1.
- R7: A transfer that ends on the last sector number without any tc_i has status bit 6 set to 1 and result byte 1 bit 7 set to 1.
- R8: The cycle after the last byte of a transfer, phase_o reads 2 (result) and int_o reads 1. int_o clears after the first result read.
- R9: Seven result bytes are read out in this order: status (bit 6 abnormal, bit 5 rejected command, bit 0 head), byte 1, byte 2, track, head, next sector number, size code. res_data_o shows the current byte, and each rd_i advances to the next one. After the seventh read, phase_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| start_sec_i | input | SEC_W | First sector number |
| eot_sec_i | input | SEC_W | Last sector number |
| size_code_i | input | CODE_W | Sector size code |
| track_i | input | 8 | Track number echoed in the result |
| head_i | input | 1 | Head number echoed in the result |
| byte_i | input | 1 | One byte transferred on the disk side |
| tc_i | input | 1 | Explicit terminal count |
| host_stop_i | input | 1 | Host stopped mid-sector |
| rd_i | input | 1 | Result byte read strobe |
| phase_o | output | 2 | 0 command, 1 execution, 2 result |
| int_o | output | 1 | Completion interrupt |
| status_o | output | 8 | Live status byte (result byte 0) |
| res_data_o | output | 8 | Current result byte |

## Verification
The in-RTL assertions check the following on every cycle:
- the byte count stays inside the sector size;
- the sector number holds between sector boundaries;
- the interrupt is raised only in the result phase and drops on a read;
- the execution phase never falls straight back to the command phase;
- a rejected command sets the flag and leaves the latched last sector number unchanged;
- the result index stays within the seven bytes.

Only the bench scenarios can show the rest:
- the exact number of fill cycles after tc_i or host_stop_i, which proves the size decoding;
- the normal versus abnormal status for each kind of ending;
- that strobes arriving while idle are ignored;
- the content and order of the seven result bytes.

// File: rtl/xts_pkg.sv
package xts_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_EXEC = 2'd1,
    PH_RES  = 2'd2
  } phase_e;
endpackage

// File: rtl/xts_byte_ctr.sv
module xts_byte_ctr #(
  parameter int CODE_W    = 3,
  parameter int BASE_LOG2 = 7,
  localparam int CNT_W    = BASE_LOG2 + (1 << CODE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [CODE_W-1:0] size_code_i,
  output logic              last_o
);
  localparam logic [CNT_W-1:0] SH_BASE = CNT_W'(CNT_W - BASE_LOG2);

  logic [CNT_W-1:0] cnt_q, sz_m1;

  assign sz_m1  = {CNT_W{1'b1}} >> (SH_BASE - CNT_W'(size_code_i));
  assign last_o = (cnt_q == sz_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (adv_i && last_o)    cnt_q <= '0;
    else if (adv_i)              cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_sector_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q <= sz_m1);
endmodule

// File: rtl/xts_sec_trk.sv
module xts_sec_trk #(
  parameter int SEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEC_W-1:0] start_i,
  input  logic             inc_i,
  input  logic [SEC_W-1:0] eot_i,
  output logic [SEC_W-1:0] sec_o,
  output logic             at_eot_o
);
  logic [SEC_W-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sec_q <= '0;
    else if (load_i) sec_q <= start_i;
    else if (inc_i)  sec_q <= sec_q + 1'b1;
  end

  assign sec_o    = sec_q;
  assign at_eot_o = (sec_q >= eot_i);

  p_sec_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(sec_q));
endmodule

// File: rtl/xts_result.sv
module xts_result #(
  parameter int NRES = 7,
  localparam int IDX_W = $clog2(NRES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 active_i,
  input  logic                 rd_i,
  input  logic [NRES-1:0][7:0] res_i,
  output logic [7:0]           data_o,
  output logic                 last_rd_o
);
  logic [IDX_W-1:0] idx_q;

  assign last_rd_o = active_i && rd_i && (idx_q == IDX_W'(NRES - 1));
  assign data_o    = res_i[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  idx_q <= '0;
    else if (start_i || last_rd_o) idx_q <= '0;
    else if (active_i && rd_i)    idx_q <= idx_q + 1'b1;
  end

  p_idx_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> idx_q < IDX_W'(NRES));
endmodule

// File: rtl/xts_seq.sv
module xts_seq
  import xts_pkg::*;
#(
  parameter int SEC_W     = 8,
  parameter int CODE_W    = 3,
  parameter int BASE_LOG2 = 7,
  parameter int NRES      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [SEC_W-1:0]  start_sec_i,
  input  logic [SEC_W-1:0]  eot_sec_i,
  input  logic [CODE_W-1:0] size_code_i,
  input  logic [7:0]        track_i,
  input  logic              head_i,
  input  logic              byte_i,
  input  logic              tc_i,
  input  logic              host_stop_i,
  input  logic              rd_i,
  output logic [1:0]        phase_o,
  output logic              int_o,
  output logic [7:0]        status_o,
  output logic [7:0]        res_data_o
);
  phase_e            phase_q;
  logic [SEC_W-1:0]  eot_q, sec;
  logic [CODE_W-1:0] code_q;
  logic [7:0]        track_q;
  logic              head_q, tc_seen_q, stop_seen_q, rej_q, abn_q, eot_hit_q, int_q;
  logic              accept, exec, tc_any, adv, last, sec_done, at_eot, finish, last_rd;
  logic [NRES-1:0][7:0] res_bytes;

  assign accept   = cmd_valid_i && (phase_q == PH_CMD);
  assign exec     = (phase_q == PH_EXEC);
  assign tc_any   = tc_seen_q || tc_i;
  // fill without strobes once any stop has been latched
  assign adv      = exec && (byte_i || tc_seen_q || stop_seen_q);
  assign sec_done = adv && last;
  assign finish   = sec_done && (tc_any || stop_seen_q || host_stop_i || at_eot);

  xts_byte_ctr #(.CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2)) u_bytes (
    .clk_i, .rst_ni, .clr_i(accept), .adv_i(adv),
    .size_code_i(code_q), .last_o(last)
  );

  xts_sec_trk #(.SEC_W(SEC_W)) u_sec (
    .clk_i, .rst_ni, .load_i(accept), .start_i(start_sec_i),
    .inc_i(sec_done), .eot_i(eot_q), .sec_o(sec), .at_eot_o(at_eot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_CMD;
      eot_q       <= '0;
      code_q      <= '0;
      track_q     <= '0;
      head_q      <= 1'b0;
      tc_seen_q   <= 1'b0;
      stop_seen_q <= 1'b0;
      rej_q       <= 1'b0;
      abn_q       <= 1'b0;
      eot_hit_q   <= 1'b0;
      int_q       <= 1'b0;
    end else begin
      if (accept) begin
        phase_q     <= PH_EXEC;
        eot_q       <= eot_sec_i;
        code_q      <= size_code_i;
        track_q     <= track_i;
        head_q      <= head_i;
        tc_seen_q   <= 1'b0;
        stop_seen_q <= 1'b0;
        rej_q       <= 1'b0;
        abn_q       <= 1'b0;
        eot_hit_q   <= 1'b0;
      end else if (cmd_valid_i) begin
        rej_q <= 1'b1;
      end
      if (exec) begin
        tc_seen_q   <= tc_any;
        stop_seen_q <= stop_seen_q || host_stop_i;
        if (finish) begin
          phase_q   <= PH_RES;
          int_q     <= 1'b1;
          abn_q     <= !tc_any;
          eot_hit_q <= at_eot && !tc_any;
        end
      end
      if (phase_q == PH_RES) begin
        if (rd_i)    int_q   <= 1'b0;
        if (last_rd) phase_q <= PH_CMD;
      end
    end
  end

  assign status_o = {1'b0, abn_q, rej_q, 4'b0, head_q};

  always_comb begin
    res_bytes    = '0;
    res_bytes[0] = status_o;
    res_bytes[1] = {eot_hit_q, 2'b0, stop_seen_q, 4'b0};
    res_bytes[2] = {7'b0, tc_seen_q};
    res_bytes[3] = track_q;
    res_bytes[4] = {7'b0, head_q};
    res_bytes[5] = 8'(sec);
    res_bytes[6] = 8'(code_q);
  end

  xts_result #(.NRES(NRES)) u_res (
    .clk_i, .rst_ni, .start_i(finish), .active_i(phase_q == PH_RES),
    .rd_i, .res_i(res_bytes), .data_o(res_data_o), .last_rd_o(last_rd)
  );

  assign phase_o = phase_q;
  assign int_o   = int_q;

  p_int_in_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> phase_o == PH_RES);
  p_int_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && rd_i) |=> !int_o);
  p_exec_no_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec |=> phase_o != PH_CMD);
  p_reject_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && phase_o != PH_CMD) |=> (rej_q && $stable(eot_q)));
endmodule

// File: tb/xts_seq_tb_top.sv
module xts_seq_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cmd_valid_i = 0, head_i = 0, byte_i = 0, tc_i = 0, host_stop_i = 0, rd_i = 0;
  logic [7:0] start_sec_i = 0, eot_sec_i = 0, track_i = 0;
  logic [2:0] size_code_i = 0;
  logic [1:0] phase_o;
  logic       int_o;
  logic [7:0] status_o, res_data_o;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rb [7];

  always #2 clk_i = ~clk_i;

  xts_seq dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int s, input int e, input int c, input int trk, input int hd);
    start_sec_i = 8'(s); eot_sec_i = 8'(e); size_code_i = 3'(c);
    track_i = 8'(trk); head_i = hd[0];
    cmd_valid_i = 1; @(negedge clk_i); cmd_valid_i = 0;
  endtask

  task automatic bytes(input int n);
    byte_i = 1; repeat (n) @(negedge clk_i); byte_i = 0;
  endtask

  task automatic pulse_tc();
    tc_i = 1; @(negedge clk_i); tc_i = 0;
  endtask

  task automatic pulse_stop();
    host_stop_i = 1; @(negedge clk_i); host_stop_i = 0;
  endtask

  task automatic wait_res(output int n);
    n = 0;
    while (phase_o != 2'd2 && n < 20000) begin
      @(negedge clk_i); n++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 7; i++) begin
      rb[i] = res_data_o;
      rd_i = 1; @(negedge clk_i); rd_i = 0;
      if (i == 0) chk("R8 int cleared by first read", int'(int_o), 0);
    end
    chk("R9 back to command phase after seventh read", int'(phase_o), 0);
  endtask

  task automatic t_reset();
    chk("R1 phase after reset", int'(phase_o), 0);
    chk("R1 int after reset", int'(int_o), 0);
    chk("R1 status after reset", int'(status_o), 0);
  endtask

  task automatic t_tc();
    int n;
    issue(1, 5, 0, 12, 0);
    chk("R2 exec after accept", int'(phase_o), 1);
    bytes(130);
    pulse_tc();
    wait_res(n);
    chk("R5 fill cycles after tc", n, 126);
    chk("R8 int on result entry", int'(int_o), 1);
    drain();
    chk("R5 normal status", int'(rb[0]), 8'h00);
    chk("R5 tc byte", int'(rb[2]), 1);
    chk("R4 next sector after tc", int'(rb[5]), 3);
    chk("R9 track field", int'(rb[3]), 12);
  endtask

  task automatic t_eot();
    issue(3, 4, 0, 0, 1);
    bytes(255);
    chk("R4 still executing before last byte", int'(phase_o), 1);
    bytes(1);
    chk("R8 result right after last byte", int'(phase_o), 2);
    chk("R8 int raised", int'(int_o), 1);
    drain();
    chk("R7 abnormal status with head", int'(rb[0]), 8'h41);
    chk("R7 end-of-track bit", int'(rb[1]), 8'h80);
    chk("R9 head field", int'(rb[4]), 1);
    chk("R4 next sector after eot", int'(rb[5]), 5);
  endtask

  task automatic t_stop();
    int n;
    issue(2, 9, 1, 0, 0);
    bytes(10);
    pulse_stop();
    wait_res(n);
    chk("R3 fill cycles for 256-byte sector", n, 246);
    drain();
    chk("R6 abnormal status", int'(rb[0]), 8'h40);
    chk("R6 stop bit", int'(rb[1]), 8'h10);
    chk("R6 no tc byte", int'(rb[2]), 0);
    chk("R4 next sector after stop", int'(rb[5]), 3);
    chk("R9 size field", int'(rb[6]), 1);
  endtask

  task automatic t_reject();
    issue(1, 1, 0, 7, 1);
    bytes(5);
    issue(9, 9, 2, 33, 0);
    chk("R2 reject keeps exec", int'(phase_o), 1);
    chk("R2 reject flag", int'(status_o[5]), 1);
    bytes(123);
    chk("R2 original size and eot kept", int'(phase_o), 2);
    issue(4, 4, 0, 1, 0);
    chk("R2 reject in result keeps phase", int'(phase_o), 2);
    drain();
    chk("R2 status with reject", int'(rb[0]), 8'h61);
    chk("R2 track unchanged", int'(rb[3]), 7);
    chk("R2 sector unchanged", int'(rb[5]), 2);
    issue(0, 0, 0, 0, 0);
    chk("R2 accept clears reject", int'(status_o[5]), 0);
    pulse_tc();
    begin int n; wait_res(n); end
    drain();
  endtask

  task automatic t_idle_ignored();
    bytes(50);
    pulse_tc();
    pulse_stop();
    chk("R3 idle strobes leave command phase", int'(phase_o), 0);
    issue(5, 5, 0, 0, 0);
    bytes(127);
    chk("R3 idle bytes not counted", int'(phase_o), 1);
    bytes(1);
    chk("R3 sector closes on 128th byte", int'(phase_o), 2);
    drain();
    chk("R3 idle tc ignored", int'(rb[0]), 8'h40);
    chk("R3 idle stop ignored", int'(rb[1]), 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_tc();
    t_eot();
    t_stop();
    t_reject();
    t_idle_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule